// File: doc/BRIEF.md
# Sequential turn signal controller

This block drives the rear lamps of a vehicle: a row of lamps on the left and a row on the right. A single left or right request makes that side's lamps light up one after another, starting at the lamp nearest the centre and growing outward. The row then goes dark for one step, and the sweep repeats for as long as the request is held. A brake request lights every lamp on both sides steadily. A request for left and right at the same moment cannot happen in normal driving, so it is treated as a fault: all lamps stay dark and a fault flag is raised.

The design is split into two parts. A four-state controller (idle, sequencing, brake, fault) decides each cycle what should happen and sends one command to a datapath. The datapath holds a step counter and a pattern shift register, so the animation length is set by a parameter rather than by the number of controller states. Two non-overlapping phase clocks are supplied from outside. The controller samples inputs and updates its state on the rising edge of phase A. The datapath and the outputs update on the following rising edge of phase B, after the commands have settled. A step-enable input sets the animation rate.

Top module: `turn_sweep_ctrl`

## Requirements
- R1: A synchronous active-high reset, sampled on both phase clocks, leaves both lamp vectors at 000 and the fault output at 0, whatever the requests are.
- R2: With only the left (or only the right) request held, that side's lamp vector runs through 001, 011, 111, 000 and then repeats. Bit 0 is the centre lamp and bit 2 the outer lamp. The first pattern, 001, appears on the first cycle of the request whether or not step-enable is high. The other side stays at 000.
- R3: During a held single-side sweep, the pattern moves to its next value only on cycles where step-enable is high. On other cycles it keeps its value.
- R4: When brake is asserted and the two turn requests are not both high, both lamp vectors are 111 and fault is 0. Brake overrides a single turn request. If brake is released while a turn request is held, the sweep restarts at 001.
- R5: When left and right are both asserted, with or without brake, fault is 1 and both lamp vectors are 000.
- R6: Once left and right are no longer both asserted, fault returns to 0 on the next cycle and the block follows the remaining requests (for example a fresh sweep at 001, or idle).
- R7: If the turn request is released during a sweep, the lamps hold their pattern until the next cycle with step-enable high. On that cycle the side goes to 000 and the block is idle. With no request, all lamps are off.
- R8: A switch straight from one side's request to the other's restarts the sweep at 001 on the new side and turns the old side to 000 on the same cycle.
- R9: Inputs are sampled on the rising edge of phase A. Outputs change only on the rising edge of phase B that follows, so between a phase-A edge and the next phase-B edge the outputs still show the previous result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Phase A clock; the controller samples inputs and updates state on its rising edge |
| clk_b | input | 1 | Phase B clock, never high together with phase A; datapath and outputs update on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Animation step enable |
| req_left | input | 1 | Left turn request |
| req_right | input | 1 | Right turn request |
| req_brake | input | 1 | Brake request |
| lamp_left | output | LAMPS | Left lamp vector, bit 0 centre |
| lamp_right | output | LAMPS | Right lamp vector, bit 0 centre |
| fault | output | 1 | High while left and right are requested together |

## Verification
The main sweep is tried in several ways:
- Step-enable held high shows the full 001-011-111-000 cycle and that it wraps around.
- Step-enable toggling on and off separates a pattern that advances from one that holds.
- A switch from left to right with step-enable low shows that a new side restarts at 001 and does not carry on the old side's step.
- Brake and fault are applied both on top of a running sweep and from idle, which checks the priority order.
- Releasing the request with step-enable low and then high shows the deferred turn-off.

Each output is also sampled between the phase-A and phase-B edges, to confirm that nothing changes before phase B.

// File: rtl/turn_sweep_pkg.sv
package turn_sweep_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_SEQ,
      ST_BRAKE,
      ST_FAULT
   } ctl_state_e;

   typedef enum logic [2:0] {
      CMD_OFF,
      CMD_FAULT,
      CMD_SOLID,
      CMD_START,
      CMD_STEP,
      CMD_HOLD
   } dp_cmd_e;

   typedef enum logic {
      SIDE_LEFT,
      SIDE_RIGHT
   } side_e;

endpackage

// File: rtl/turn_sweep_fsm.sv
module turn_sweep_fsm
   import turn_sweep_pkg::*;
(
   input  logic     clk_a,
   input  logic     rst,
   input  logic     step_en,
   input  logic     req_l,
   input  logic     req_r,
   input  logic     req_brake,
   output dp_cmd_e  cmd_o,
   output side_e    side_o
);

   ctl_state_e st_q, st_n;
   dp_cmd_e    cmd_q, cmd_n;
   side_e      side_q, side_n;
   side_e      want_side;
   logic       both_req;
   logic       one_req;

   assign both_req  = req_l & req_r;
   assign one_req   = req_l ^ req_r;
   assign want_side = req_r ? SIDE_RIGHT : SIDE_LEFT;

   always_comb begin
      st_n   = st_q;
      side_n = side_q;
      cmd_n  = CMD_HOLD;
      if (both_req) begin
         st_n  = ST_FAULT;
         cmd_n = CMD_FAULT;
      end else if (req_brake) begin
         st_n  = ST_BRAKE;
         cmd_n = CMD_SOLID;
      end else if (one_req) begin
         if (st_q == ST_SEQ && side_q == want_side) begin
            cmd_n = step_en ? CMD_STEP : CMD_HOLD;
         end else begin
            st_n   = ST_SEQ;
            side_n = want_side;
            cmd_n  = CMD_START;
         end
      end else if (st_q == ST_SEQ && !step_en) begin
         cmd_n = CMD_HOLD;
      end else begin
         st_n  = ST_IDLE;
         cmd_n = CMD_OFF;
      end
   end

   always_ff @(posedge clk_a) begin
      if (rst) begin
         st_q   <= ST_IDLE;
         cmd_q  <= CMD_OFF;
         side_q <= SIDE_LEFT;
      end else begin
         st_q   <= st_n;
         cmd_q  <= cmd_n;
         side_q <= side_n;
      end
   end

   assign cmd_o  = cmd_q;
   assign side_o = side_q;

   // R5: a double request always lands in the fault state
   assert_fault_entry_R5: assert property (@(posedge clk_a) disable iff (rst)
      both_req |=> (st_q == ST_FAULT && cmd_q == CMD_FAULT));

   // R4: brake without a double request wins over a single turn request
   assert_brake_wins_R4: assert property (@(posedge clk_a) disable iff (rst)
      (!both_req && req_brake) |=> (st_q == ST_BRAKE && cmd_q == CMD_SOLID));

   // R3: same-side sweep without step enable only holds
   assert_hold_no_step_R3: assert property (@(posedge clk_a) disable iff (rst)
      (st_q == ST_SEQ && one_req && !req_brake && side_q == want_side && !step_en)
      |=> (cmd_q == CMD_HOLD && st_q == ST_SEQ));

   // R7: released request waits for a step before going idle
   assert_defer_off_R7: assert property (@(posedge clk_a) disable iff (rst)
      (st_q == ST_SEQ && !req_l && !req_r && !req_brake && !step_en)
      |=> (st_q == ST_SEQ && cmd_q == CMD_HOLD));

   // R8: a request for the other side restarts the sweep
   assert_side_switch_R8: assert property (@(posedge clk_a) disable iff (rst)
      (st_q == ST_SEQ && one_req && !req_brake && side_q != want_side)
      |=> (cmd_q == CMD_START));

endmodule

// File: rtl/turn_sweep_dp.sv
module turn_sweep_dp
   import turn_sweep_pkg::*;
#(
   parameter int LAMPS = 3
)(
   input  logic             clk_b,
   input  logic             rst,
   input  dp_cmd_e          cmd_i,
   input  side_e            side_i,
   output logic [LAMPS-1:0] lamp_l_o,
   output logic [LAMPS-1:0] lamp_r_o,
   output logic             fault_o
);

   localparam int CNT_W = $clog2(LAMPS + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LAMPS);
   localparam logic [LAMPS-1:0] PAT_FIRST = LAMPS'(1);
   localparam logic [LAMPS-1:0] PAT_ONE   = LAMPS'(1);

   logic [LAMPS-1:0] pat_q;
   logic [CNT_W-1:0] cnt_q;
   logic             solid_q;
   logic             fault_q;
   side_e            side_q;
   logic [LAMPS-1:0] lamp_vec [2];

   always_ff @(posedge clk_b) begin
      if (rst) begin
         pat_q   <= '0;
         cnt_q   <= '0;
         solid_q <= 1'b0;
         fault_q <= 1'b0;
         side_q  <= SIDE_LEFT;
      end else begin
         case (cmd_i)
            CMD_OFF, CMD_FAULT, CMD_SOLID: begin
               pat_q   <= '0;
               cnt_q   <= '0;
               solid_q <= (cmd_i == CMD_SOLID);
               fault_q <= (cmd_i == CMD_FAULT);
            end
            CMD_START: begin
               pat_q   <= PAT_FIRST;
               cnt_q   <= CNT_W'(1);
               side_q  <= side_i;
               solid_q <= 1'b0;
               fault_q <= 1'b0;
            end
            CMD_STEP: begin
               if (cnt_q == CNT_LAST) begin
                  pat_q <= '0;
                  cnt_q <= '0;
               end else begin
                  pat_q <= {pat_q[LAMPS-2:0], 1'b1};
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: begin
            end
         endcase
      end
   end

   for (genvar s = 0; s < 2; s++) begin : g_side
      localparam logic IS_RIGHT = (s == 1);
      assign lamp_vec[s] = solid_q ? {LAMPS{1'b1}} :
                           ((side_q == SIDE_RIGHT) == IS_RIGHT) ? pat_q : '0;
   end

   assign lamp_l_o = lamp_vec[0];
   assign lamp_r_o = lamp_vec[1];
   assign fault_o  = fault_q;

   // R2: each side only ever shows a centre-out thermometer pattern
   assert_thermo_R2: assert property (@(posedge clk_b) disable iff (rst)
      ((lamp_l_o & (lamp_l_o + PAT_ONE)) == '0) &&
      ((lamp_r_o & (lamp_r_o + PAT_ONE)) == '0));

   // R5: fault keeps every lamp dark
   assert_fault_dark_R5: assert property (@(posedge clk_b) disable iff (rst)
      fault_o |-> (lamp_l_o == '0 && lamp_r_o == '0));

   // R8: outside brake at most one side is lit
   assert_one_side_R8: assert property (@(posedge clk_b) disable iff (rst)
      !solid_q |-> !((|lamp_l_o) && (|lamp_r_o)));

   // R3: a hold command leaves the pattern unchanged
   assert_hold_stable_R3: assert property (@(posedge clk_b) disable iff (rst)
      (cmd_i == CMD_HOLD) |=> $stable(pat_q));

endmodule

// File: rtl/turn_sweep_ctrl.sv
module turn_sweep_ctrl
   import turn_sweep_pkg::*;
#(
   parameter int LAMPS = 3
)(
   input  logic             clk_a,
   input  logic             clk_b,
   input  logic             rst,
   input  logic             step_en,
   input  logic             req_left,
   input  logic             req_right,
   input  logic             req_brake,
   output logic [LAMPS-1:0] lamp_left,
   output logic [LAMPS-1:0] lamp_right,
   output logic             fault
);

   if (LAMPS < 2 || LAMPS > 16) begin : g_bad_lamps
      $error("turn_sweep_ctrl: LAMPS must lie in 2..16");
   end

   dp_cmd_e cmd;
   side_e   side;

   turn_sweep_fsm u_fsm (
      .clk_a     (clk_a),
      .rst       (rst),
      .step_en   (step_en),
      .req_l     (req_left),
      .req_r     (req_right),
      .req_brake (req_brake),
      .cmd_o     (cmd),
      .side_o    (side)
   );

   turn_sweep_dp #(.LAMPS(LAMPS)) u_dp (
      .clk_b    (clk_b),
      .rst      (rst),
      .cmd_i    (cmd),
      .side_i   (side),
      .lamp_l_o (lamp_left),
      .lamp_r_o (lamp_right),
      .fault_o  (fault)
   );

endmodule

// File: tb/turn_sweep_ctrl_tb.sv
`timescale 1ns/1ps
module turn_sweep_ctrl_tb;

   localparam int LAMPS = 3;

   logic clk_a = 1'b0, clk_b = 1'b0;
   logic rst = 1'b1, step_en = 1'b0;
   logic req_left = 1'b0, req_right = 1'b0, req_brake = 1'b0;
   logic [LAMPS-1:0] lamp_left, lamp_right;
   logic fault;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;
   bit have_prev = 0;

   // reference model: 0 idle, 1 sweeping, 2 brake, 3 fault
   int m_mode = 0;
   int m_dir  = 0;   // 0 left, 1 right
   int m_lit  = 0;   // number of lamps lit in the sweep
   logic [LAMPS-1:0] e_l = '0, e_r = '0;
   logic e_f = 1'b0;

   turn_sweep_ctrl #(.LAMPS(LAMPS)) u_dut (
      .clk_a(clk_a), .clk_b(clk_b), .rst(rst), .step_en(step_en),
      .req_left(req_left), .req_right(req_right), .req_brake(req_brake),
      .lamp_left(lamp_left), .lamp_right(lamp_right), .fault(fault)
   );

   // 8 ns period: phase A high 1..3, phase B high 5..7
   initial forever begin
      #1 clk_a = 1'b1;
      #2 clk_a = 1'b0;
      #2 clk_b = 1'b1;
      #2 clk_b = 1'b0;
      #1;
   end

   function automatic void model_step(int r, int l, int rr, int b, int se);
      int d;
      d = rr;
      if (r != 0) begin
         m_mode = 0; m_lit = 0; m_dir = 0;
      end else if (l != 0 && rr != 0) begin
         m_mode = 3; m_lit = 0;
      end else if (b != 0) begin
         m_mode = 2; m_lit = 0;
      end else if (l != 0 || rr != 0) begin
         if (m_mode == 1 && m_dir == d) begin
            if (se != 0) m_lit = (m_lit == LAMPS) ? 0 : m_lit + 1;
         end else begin
            m_mode = 1; m_dir = d; m_lit = 1;
         end
      end else if (!(m_mode == 1 && se == 0)) begin
         m_mode = 0; m_lit = 0;
      end
      e_l = '0; e_r = '0; e_f = 1'b0;
      case (m_mode)
         1: if (m_dir == 0) e_l = LAMPS'((1 << m_lit) - 1);
            else            e_r = LAMPS'((1 << m_lit) - 1);
         2: begin e_l = '1; e_r = '1; end
         3: e_f = 1'b1;
         default: ;
      endcase
   endfunction

   task automatic check(input string tag);
      n_checks++;
      if (lamp_left !== e_l || lamp_right !== e_r || fault !== e_f) begin
         n_fail++;
         $display("FAIL %s t=%0t: left=%b right=%b fault=%b expected left=%b right=%b fault=%b",
                  tag, $time, lamp_left, lamp_right, fault, e_l, e_r, e_f);
      end
   endtask

   task automatic tick(input logic r, input logic l, input logic rr,
                       input logic b, input logic se, input string tag);
      rst = r; req_left = l; req_right = rr; req_brake = b; step_en = se;
      @(posedge clk_a); #1;
      if (have_prev) check("R9");     // phase A alone must not move outputs
      model_step(int'(r), int'(l), int'(rr), int'(b), int'(se));
      @(posedge clk_b); #2;
      check(tag);
      have_prev = 1;
   endtask

   initial begin
      // R1: reset dominates a held request
      tick(1, 1, 0, 0, 1, "R1");
      tick(1, 1, 0, 1, 1, "R1");
      tick(1, 0, 0, 0, 0, "R1");
      tick(0, 0, 0, 0, 1, "R7");
      // R2: left sweep, step every cycle, two full laps
      for (int i = 0; i < 9; i++) tick(0, 1, 0, 0, 1, "R2");
      // R3: step enable alternating
      for (int i = 0; i < 10; i++) tick(0, 1, 0, 0, logic'(i % 2), "R3");
      // R8: switch to right without a step
      tick(0, 0, 1, 0, 0, "R8");
      tick(0, 0, 1, 0, 0, "R3");
      for (int i = 0; i < 5; i++) tick(0, 0, 1, 0, 1, "R2");
      tick(0, 1, 0, 0, 1, "R8");
      tick(0, 1, 0, 0, 1, "R2");
      // R4: brake over a sweep, then release with request held
      tick(0, 1, 0, 1, 1, "R4");
      tick(0, 1, 0, 1, 0, "R4");
      tick(0, 0, 0, 1, 1, "R4");
      tick(0, 0, 1, 1, 1, "R4");
      tick(0, 0, 1, 0, 0, "R4");
      tick(0, 0, 1, 0, 1, "R2");
      // R5: double request, with and without brake
      tick(0, 1, 1, 0, 1, "R5");
      tick(0, 1, 1, 1, 1, "R5");
      tick(0, 1, 1, 0, 0, "R5");
      // R6: fault clears into a fresh sweep, then into brake, then idle
      tick(0, 1, 0, 0, 0, "R6");
      tick(0, 1, 1, 0, 1, "R5");
      tick(0, 0, 0, 1, 0, "R6");
      tick(0, 1, 1, 0, 0, "R5");
      tick(0, 0, 0, 0, 0, "R6");
      // R7: release mid-sweep, hold until a step arrives
      tick(0, 1, 0, 0, 0, "R2");
      tick(0, 1, 0, 0, 1, "R2");
      for (int i = 0; i < 3; i++) tick(0, 0, 0, 0, 0, "R7");
      tick(0, 0, 0, 0, 1, "R7");
      tick(0, 0, 0, 0, 0, "R7");
      tick(0, 0, 1, 0, 0, "R7");
      // R1: reset in the middle of a sweep
      tick(0, 0, 1, 0, 1, "R2");
      tick(1, 0, 1, 0, 1, "R1");
      tick(0, 0, 1, 0, 0, "R2");
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule